// File: doc/BRIEF.md
# Dual-Clock Queue with Programmable Thresholds

This block is an 18-bit first-in/first-out store. A producer writes on one clock and a consumer reads on a second, unrelated clock. The depth is a power of two set by a parameter. The read side works in one of two timings. In standard timing every word leaves only on a read request. In fall-through timing the oldest word is presented on the output without any request, and each later word follows once the current one is taken. Besides full and empty status, the block raises half-full, almost-full and almost-empty flags. The two almost thresholds come from a preset code chosen at reset, or are loaded as whole words or one bit at a time.

A master reset clears both pointers and captures the timing mode and the preset code. A partial reset clears only the pointers and keeps the mode and thresholds. A retransmit request rewinds the read side to the start of storage so that words already read can be read again.

Top module: `dual_clk_queue`

## Requirements
- R1: While mstRstN is low, each rising wrClk edge captures fwftSel as the timing mode and presetSel as the threshold code. After master reset, rdData is 0, almostEmpty is 1, and halfFull and almostFull are 0. In standard mode statusFull is 0 and statusEmpty is 1. In fall-through mode statusFull is 1 and statusEmpty is 0.
- R2: A low level on partRstN empties the queue and sets rdData to 0. The mode and both thresholds keep their values.
- R3: In standard mode statusFull is 1 when 2^ADDR_W words are stored. A write request while full is dropped and its word is never read out.
- R4: A read request while storage is empty is ignored, and rdData keeps its last value.
- R5: In standard mode, a read request sampled on a rising rdClk edge places the oldest stored word on rdData at that edge. Words leave in the order they were written.
- R6: In fall-through mode, the oldest word is placed on rdData with no read request, and statusEmpty goes to 1 to mark it valid. The word holds until a read request is sampled, and the next word (if any) replaces it at that same edge. statusFull is 1 while storage can accept a word.
- R7: halfFull is 1 when the stored count, as seen from the write side, is at least 2^ADDR_W / 2.
- R8: almostFull is 1 when the write-side count is at least 2^ADDR_W minus the full-side threshold.
- R9: almostEmpty is 1 when the read-side count of words in storage is at most the empty-side threshold. A word held in the fall-through output stage is not counted.
- R10: Preset code k (0..7) sets both thresholds to the smaller of 2^(k+3)-1 and 2^ADDR_W / 2.
- R11: With cfgLoad high on a wrClk edge, wrData[ADDR_W:0] is loaded into the full-side threshold if cfgSel is 1, or into the empty-side threshold if cfgSel is 0. A write request on that same edge is ignored.
- R12: With serEn high and cfgLoad low on a wrClk edge, serIn shifts into the most significant bit of the chain {full-side, empty-side}, and the chain moves right by one. The empty-side bits are sent first, least significant bit first, followed by the full-side bits in the same order.
- R13: A pulse on rtEn, taken on rdClk, returns the read position to the first storage location. The words written since reset can then be read again in order. It is used only while no writes occur and fewer than 2^ADDR_W words have been written since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| mstRstN | input | 1 | Master reset, active low |
| partRstN | input | 1 | Partial reset, active low, clears pointers only |
| fwftSel | input | 1 | 1 selects fall-through timing; captured during master reset |
| presetSel | input | 3 | Threshold preset code; captured during master reset |
| wrEn | input | 1 | Write request |
| wrData | input | WIDTH | Write word; low bits also carry a threshold during a load |
| cfgLoad | input | 1 | Word-parallel threshold load strobe |
| cfgSel | input | 1 | Load target: 1 full-side, 0 empty-side |
| serEn | input | 1 | Serial threshold shift enable |
| serIn | input | 1 | Serial threshold bit |
| rdEn | input | 1 | Read request |
| rtEn | input | 1 | Retransmit request |
| rdData | output | WIDTH | Read word |
| statusFull | output | 1 | Full (standard) or input-ready (fall-through) |
| statusEmpty | output | 1 | Empty (standard) or output-ready (fall-through) |
| halfFull | output | 1 | At least half of storage in use |
| almostFull | output | 1 | Full-side threshold reached |
| almostEmpty | output | 1 | Count at or below empty-side threshold |

## Verification
The bench builds the queue with WIDTH 18 and ADDR_W 4, which gives sixteen locations. The full boundary and a dropped write while full are then reached within a few dozen write cycles. At this depth every preset code from 1 upward clips to 8, so the preset test shows the depth/2 limit. The almost thresholds sit a few words from empty and full, so the one-word steps on each side of every threshold can be checked directly.

// File: rtl/dcq_pkg.sv
package dcq_pkg;

  typedef struct packed {
    logic push;
    logic pop;
  } memStrobe_t;

  function automatic int unsigned presetOffset(input logic [2:0] code, input int unsigned half);
    int unsigned v;
    v = (32'd8 << code) - 32'd1;
    return (v > half) ? half : v;
  endfunction

endpackage

// File: rtl/dcq_data.sv
module dcq_data #(
  parameter int WIDTH  = 18,
  parameter int ADDR_W = 6
) (
  input  logic                   wrClk,
  input  logic                   rdClk,
  input  logic                   rstN,
  input  dcq_pkg::memStrobe_t    strobe,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [ADDR_W-1:0]      rdAddr,
  input  logic [WIDTH-1:0]       wrData,
  output logic [WIDTH-1:0]       rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.push) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (strobe.pop) rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/dcq_ctrl.sv
module dcq_ctrl #(
  parameter int ADDR_W = 6
) (
  input  logic                   wrClk,
  input  logic                   rdClk,
  input  logic                   mstRstN,
  input  logic                   partRstN,
  input  logic                   fwftSel,
  input  logic [2:0]             presetSel,
  input  logic                   wrEn,
  input  logic                   cfgLoad,
  input  logic                   cfgSel,
  input  logic [ADDR_W:0]        cfgWord,
  input  logic                   serEn,
  input  logic                   serIn,
  input  logic                   rdEn,
  input  logic                   rtEn,
  output dcq_pkg::memStrobe_t    strobe,
  output logic [ADDR_W-1:0]      wrAddr,
  output logic [ADDR_W-1:0]      rdAddr,
  output logic                   ptrRstN,
  output logic                   statusFull,
  output logic                   statusEmpty,
  output logic                   halfFull,
  output logic                   almostFull,
  output logic                   almostEmpty
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;
  localparam int OFF_W = ADDR_W + 1;
  localparam int HALF  = DEPTH / 2;

  function automatic logic [PTR_W-1:0] bin2gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign ptrRstN = mstRstN & partRstN;

  // ---------------- configuration (write clock) ----------------
  logic             fwftMode;
  logic [OFF_W-1:0] aeOff, afOff;

  always_ff @(posedge wrClk) begin
    if (!mstRstN) begin
      fwftMode <= fwftSel;
      aeOff    <= OFF_W'(dcq_pkg::presetOffset(presetSel, HALF));
      afOff    <= OFF_W'(dcq_pkg::presetOffset(presetSel, HALF));
    end else if (cfgLoad) begin
      if (cfgSel) afOff <= cfgWord;
      else        aeOff <= cfgWord;
    end else if (serEn) begin
      {afOff, aeOff} <= {serIn, afOff, aeOff[OFF_W-1:1]};
    end
  end

  // ---------------- write side ----------------
  logic [PTR_W-1:0] wrBin, wrGray, rdGrayS1, rdGrayS2, wrCount;
  logic             fullW, push;

  assign wrCount = wrBin - gray2bin(rdGrayS2);
  assign fullW   = (wrCount == PTR_W'(DEPTH));
  assign push    = wrEn && !fullW && !cfgLoad;

  always_ff @(posedge wrClk or negedge ptrRstN) begin
    if (!ptrRstN) begin
      wrBin    <= '0;
      wrGray   <= '0;
      rdGrayS1 <= '0;
      rdGrayS2 <= '0;
    end else begin
      rdGrayS1 <= rdGray;
      rdGrayS2 <= rdGrayS1;
      if (push) begin
        wrBin  <= wrBin + 1'b1;
        wrGray <= bin2gray(wrBin + 1'b1);
      end
    end
  end

  // ---------------- read side ----------------
  logic [PTR_W-1:0] rdBin, rdGray, wrGrayS1, wrGrayS2, rdCount;
  logic             memEmpty, outValid, pop;

  assign rdCount  = gray2bin(wrGrayS2) - rdBin;
  assign memEmpty = (rdCount == '0);
  assign pop      = !rtEn && !memEmpty && (fwftMode ? (!outValid || rdEn) : rdEn);

  always_ff @(posedge rdClk or negedge ptrRstN) begin
    if (!ptrRstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      outValid <= 1'b0;
      wrGrayS1 <= '0;
      wrGrayS2 <= '0;
    end else begin
      wrGrayS1 <= wrGray;
      wrGrayS2 <= wrGrayS1;
      if (rtEn) begin
        rdBin    <= '0;
        rdGray   <= '0;
        outValid <= 1'b0;
      end else begin
        if (pop) begin
          rdBin  <= rdBin + 1'b1;
          rdGray <= bin2gray(rdBin + 1'b1);
        end
        if (pop)       outValid <= 1'b1;
        else if (rdEn) outValid <= 1'b0;
      end
    end
  end

  // ---------------- outputs ----------------
  assign strobe.push = push;
  assign strobe.pop  = pop;
  assign wrAddr      = wrBin[ADDR_W-1:0];
  assign rdAddr      = rdBin[ADDR_W-1:0];
  assign statusFull  = fwftMode ? !fullW : fullW;
  assign statusEmpty = fwftMode ? outValid : memEmpty;
  assign halfFull    = (wrCount >= PTR_W'(HALF));
  assign almostFull  = (wrCount >= (PTR_W'(DEPTH) - afOff));
  assign almostEmpty = (rdCount <= aeOff);

  // ---------------- assertions ----------------
  p_count_bound_r3: assert property (@(posedge wrClk) disable iff (!ptrRstN)
    wrCount <= PTR_W'(DEPTH));

  p_no_overflow_r3: assert property (@(posedge wrClk) disable iff (!ptrRstN)
    (fullW && wrEn) |=> $stable(wrBin));

  p_no_underflow_r4: assert property (@(posedge rdClk) disable iff (!ptrRstN)
    (!fwftMode && memEmpty && rdEn && !rtEn) |=> $stable(rdBin));

  p_fwft_hold_r6: assert property (@(posedge rdClk) disable iff (!ptrRstN)
    (fwftMode && outValid && !rdEn && !rtEn) |=> outValid);

  p_gray_step_r5: assert property (@(posedge wrClk) disable iff (!ptrRstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);

endmodule

// File: rtl/dual_clk_queue.sv
module dual_clk_queue #(
  parameter int WIDTH  = 18,
  parameter int ADDR_W = 6
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mstRstN,
  input  logic              partRstN,
  input  logic              fwftSel,
  input  logic [2:0]        presetSel,
  input  logic              wrEn,
  input  logic [WIDTH-1:0]  wrData,
  input  logic              cfgLoad,
  input  logic              cfgSel,
  input  logic              serEn,
  input  logic              serIn,
  input  logic              rdEn,
  input  logic              rtEn,
  output logic [WIDTH-1:0]  rdData,
  output logic              statusFull,
  output logic              statusEmpty,
  output logic              halfFull,
  output logic              almostFull,
  output logic              almostEmpty
);
  localparam int OFF_W = ADDR_W + 1;

  dcq_pkg::memStrobe_t   strobe;
  logic [ADDR_W-1:0]     wrAddr, rdAddr;
  logic                  ptrRstN;

  dcq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .mstRstN(mstRstN), .partRstN(partRstN),
    .fwftSel(fwftSel), .presetSel(presetSel), .wrEn(wrEn),
    .cfgLoad(cfgLoad), .cfgSel(cfgSel), .cfgWord(wrData[OFF_W-1:0]),
    .serEn(serEn), .serIn(serIn), .rdEn(rdEn), .rtEn(rtEn),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr), .ptrRstN(ptrRstN),
    .statusFull(statusFull), .statusEmpty(statusEmpty), .halfFull(halfFull),
    .almostFull(almostFull), .almostEmpty(almostEmpty)
  );

  dcq_data #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_data (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(ptrRstN), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: tb/dual_clk_queue_tb.sv
module dual_clk_queue_tb;
  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 14;
  localparam int W  = 18;
  localparam int AW = 4;

  // vector: [8:4] words to add, [3] full, [2] half, [1] almostFull, [0] almostEmpty
  localparam logic [8:0] VEC [6] = '{
    {5'd0, 4'b0001}, {5'd7, 4'b0001}, {5'd1, 4'b0100},
    {5'd1, 4'b0110}, {5'd7, 4'b1110}, {5'd1, 4'b1110}
  };

  logic wrClk = 1'b0, rdClk = 1'b0;
  logic mstRstN = 1'b0, partRstN = 1'b1, fwftSel = 1'b0;
  logic [2:0] presetSel = '0;
  logic wrEn = 1'b0, cfgLoad = 1'b0, cfgSel = 1'b0, serEn = 1'b0, serIn = 1'b0;
  logic rdEn = 1'b0, rtEn = 1'b0;
  logic [W-1:0] wrData = '0, rdData;
  logic statusFull, statusEmpty, halfFull, almostFull, almostEmpty;
  int checks = 0, fails = 0, seq = 0;

  always #(WR_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2) rdClk = ~rdClk;

  dual_clk_queue #(.WIDTH(W), .ADDR_W(AW)) u_dut (
    .wrClk(wrClk), .rdClk(rdClk), .mstRstN(mstRstN), .partRstN(partRstN),
    .fwftSel(fwftSel), .presetSel(presetSel), .wrEn(wrEn), .wrData(wrData),
    .cfgLoad(cfgLoad), .cfgSel(cfgSel), .serEn(serEn), .serIn(serIn),
    .rdEn(rdEn), .rtEn(rtEn), .rdData(rdData), .statusFull(statusFull),
    .statusEmpty(statusEmpty), .halfFull(halfFull), .almostFull(almostFull),
    .almostEmpty(almostEmpty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge rdClk);
    repeat (5) @(negedge wrClk);
  endtask

  task automatic masterReset(input logic fwft, input logic [2:0] code);
    mstRstN = 1'b0; fwftSel = fwft; presetSel = code;
    repeat (4) @(negedge wrClk);
    repeat (4) @(negedge rdClk);
    @(negedge wrClk) mstRstN = 1'b1;
    settle();
  endtask

  task automatic pushWord(input logic [W-1:0] d);
    @(negedge wrClk) begin wrEn = 1'b1; wrData = d; end
    @(negedge wrClk) wrEn = 1'b0;
  endtask

  task automatic pushMany(input int n);
    for (int k = 0; k < n; k++) begin pushWord(W'(seq)); seq++; end
    settle();
  endtask

  task automatic popWord();
    @(negedge rdClk) rdEn = 1'b1;
    @(negedge rdClk) rdEn = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(WR_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state, standard mode, preset 0 -> thresholds 7
    masterReset(1'b0, 3'd0);
    chk("R1 rdData", 32'(rdData), 0);
    chk("R1 statusEmpty", 32'(statusEmpty), 1);
    chk("R1 statusFull", 32'(statusFull), 0);
    chk("R1 halfFull", 32'(halfFull), 0);
    chk("R1 almostFull", 32'(almostFull), 0);
    chk("R1 almostEmpty", 32'(almostEmpty), 1);

    // table walk: fill levels 0,7,8,9,16,16(dropped write)
    for (int v = 0; v < 6; v++) begin
      pushMany(int'(VEC[v][8:4]));
      chk("R3 full", 32'(statusFull), 32'(VEC[v][3]));
      chk("R7 halfFull", 32'(halfFull), 32'(VEC[v][2]));
      chk("R8 almostFull", 32'(almostFull), 32'(VEC[v][1]));
      chk("R9 almostEmpty", 32'(almostEmpty), 32'(VEC[v][0]));
    end

    // R5 order, R3 dropped word never appears
    for (int i = 0; i < 16; i++) begin
      popWord();
      chk("R5 order", 32'(rdData), 32'(i));
    end
    settle();
    chk("R3 dropped write absent", 32'(statusEmpty), 1);
    popWord();
    chk("R4 read on empty holds data", 32'(rdData), 15);

    // R10 preset code 1 -> min(15, 8) = 8
    masterReset(1'b0, 3'd1);
    pushMany(7);
    chk("R10 almostFull below", 32'(almostFull), 0);
    pushMany(1);
    chk("R10 almostFull at 8", 32'(almostFull), 1);
    chk("R10 almostEmpty at 8", 32'(almostEmpty), 1);
    pushMany(1);
    chk("R10 almostEmpty at 9", 32'(almostEmpty), 0);

    // R11 parallel load: empty-side 2, full-side 3, writes ignored during load
    masterReset(1'b0, 3'd0);
    @(negedge wrClk) begin cfgLoad = 1'b1; cfgSel = 1'b0; wrEn = 1'b1; wrData = W'(2); end
    @(negedge wrClk) begin cfgSel = 1'b1; wrData = W'(3); end
    @(negedge wrClk) begin cfgLoad = 1'b0; wrEn = 1'b0; end
    settle();
    chk("R11 load does not write", 32'(statusEmpty), 1);
    pushMany(3);
    chk("R11 almostEmpty at 3", 32'(almostEmpty), 0);
    pushMany(9);
    chk("R11 almostFull at 12", 32'(almostFull), 0);
    pushMany(1);
    chk("R11 almostFull at 13", 32'(almostFull), 1);

    // R2 partial reset keeps thresholds
    @(negedge wrClk) partRstN = 1'b0;
    repeat (3) @(negedge rdClk);
    @(negedge wrClk) partRstN = 1'b1;
    settle();
    chk("R2 empty", 32'(statusEmpty), 1);
    chk("R2 rdData", 32'(rdData), 0);
    chk("R2 almostFull", 32'(almostFull), 0);
    pushMany(2);
    chk("R2 almostEmpty at 2", 32'(almostEmpty), 1);
    pushMany(1);
    chk("R2 almostEmpty at 3 kept offset", 32'(almostEmpty), 0);
    pushMany(10);
    chk("R2 almostFull at 13 kept offset", 32'(almostFull), 1);

    // R12 serial load: empty-side 4 then full-side 5, LSB first
    masterReset(1'b0, 3'd0);
    for (int b = 0; b < 10; b++) begin
      @(negedge wrClk) begin
        serEn = 1'b1;
        serIn = (b < 5) ? ((5'd4 >> b) & 5'd1) != 0 : ((5'd5 >> (b - 5)) & 5'd1) != 0;
      end
    end
    @(negedge wrClk) serEn = 1'b0;
    pushMany(4);
    chk("R12 almostEmpty at 4", 32'(almostEmpty), 1);
    pushMany(1);
    chk("R12 almostEmpty at 5", 32'(almostEmpty), 0);
    pushMany(5);
    chk("R12 almostFull at 10", 32'(almostFull), 0);
    pushMany(1);
    chk("R12 almostFull at 11", 32'(almostFull), 1);

    // R6 fall-through timing
    masterReset(1'b1, 3'd0);
    chk("R1 fwft outReady", 32'(statusEmpty), 0);
    chk("R6 fwft inReady", 32'(statusFull), 1);
    pushWord(W'('h2A5A));
    settle();
    chk("R6 first word falls through", 32'(rdData), 32'h2A5A);
    chk("R6 outReady", 32'(statusEmpty), 1);
    pushWord(W'('h111));
    pushWord(W'('h222));
    settle();
    chk("R6 held without read", 32'(rdData), 32'h2A5A);
    popWord();
    chk("R6 second word", 32'(rdData), 32'h111);
    popWord();
    chk("R6 third word", 32'(rdData), 32'h222);
    popWord();
    settle();
    chk("R6 outReady drops", 32'(statusEmpty), 0);

    // R13 retransmit
    masterReset(1'b0, 3'd0);
    for (int i = 0; i < 4; i++) pushWord(W'('h40 + i));
    settle();
    for (int i = 0; i < 4; i++) begin
      popWord();
      chk("R13 first pass", 32'(rdData), 32'('h40 + i));
    end
    settle();
    chk("R13 empty before rewind", 32'(statusEmpty), 1);
    @(negedge rdClk) rtEn = 1'b1;
    @(negedge rdClk) rtEn = 1'b0;
    settle();
    chk("R13 not empty after rewind", 32'(statusEmpty), 0);
    for (int i = 0; i < 4; i++) begin
      popWord();
      chk("R13 second pass", 32'(rdData), 32'('h40 + i));
    end

    summary();
    $finish;
  end

endmodule